// File: doc/BRIEF.md
# Receive Buffer Partial-Packet Flush Timer

This block sits beside a receive buffer that collects bytes into packets bound for a host. A short burst of data that never fills a packet would otherwise sit in the buffer forever. The block measures how long the newest byte has waited, in milliseconds, and raises a one-cycle flush request when a programmable latency has passed. It also raises the request at once when the buffer reports full.

Time advances only on a 1 ms tick strobe supplied by the surrounding logic, so the block has no clock-frequency parameter. The latency register holds a value from 2 to 255 ms and comes up as 16 ms after reset. Software or a control path writes it through a simple write strobe. Each flush disarms the timer until the next byte is written, so a buffer that is left non-empty does not produce a stream of requests.

Top module: `rx_flush_timer`

## Requirements
- R1: After synchronous reset `flush_req` is 0 and the latency is 16 ms: with the buffer non-empty, the flush follows the 16th tick after the last byte write.
- R2: A `cfg_wr` pulse loads `cfg_ms` (unsigned, in 1 ms units) as the new latency; values 2 to 255 are used unchanged and the value holds until the next write.
- R3: A written value of 0 or 1 is stored as 2.
- R4: With the buffer non-empty and the timer armed, `flush_req` goes high in the cycle after the edge that samples the N-th `ms_tick` since the last `byte_wr`, where N is the latency.
- R5: While `buf_nempty` is 0 the count is held at zero and the timer disarms; ticks in that time are not counted and produce no flush.
- R6: A `byte_wr` clears the count and arms the timer; a tick that arrives in the same cycle as `byte_wr` is not counted.
- R7: When armed and `buf_full` is 1, `flush_req` goes high in the next cycle and the count clears; a later timeout is measured from the next byte write.
- R8: `flush_req` is high for exactly one cycle; no further request follows until a new `byte_wr` arrives, however long the buffer stays non-empty or full.
- R9: The count advances only on cycles where `ms_tick` is 1; idle clock cycles do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| byte_wr | input | 1 | A byte was written into the receive buffer |
| buf_nempty | input | 1 | Receive buffer holds at least one byte |
| buf_full | input | 1 | Receive buffer holds a full packet |
| cfg_wr | input | 1 | Write strobe for the latency register |
| cfg_ms | input | 8 | New latency in milliseconds |
| flush_req | output | 1 | Registered one-cycle flush request |

## Verification
A wrong count or latency value shows as a flush request on the wrong tick. The bench counts ticks from the last byte write and compares the index of the first request with the latency it expects, so an off-by-one is visible on the very tick where it occurs. A stuck arm flag shows as a second request in the hundreds of ticks that follow a flush. A count that fails to clear on a byte write, on an empty buffer or on a full flush shows as a request that comes early in the next measured window.

// File: rtl/rft_pkg.sv
package rft_pkg;
  localparam int RFT_MS_W       = 8;
  localparam int RFT_MS_DEFAULT = 16;
  localparam int RFT_MS_MIN     = 2;
endpackage

// File: rtl/rft_latency_reg.sv
module rft_latency_reg #(
  parameter int MS_W       = rft_pkg::RFT_MS_W,
  parameter int MS_DEFAULT = rft_pkg::RFT_MS_DEFAULT,
  parameter int MS_MIN     = rft_pkg::RFT_MS_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [MS_W-1:0] cfg_ms,
  output logic [MS_W-1:0] latency
);
  localparam logic [MS_W-1:0] MIN_V = MS_W'(MS_MIN);
  localparam logic [MS_W-1:0] DEF_V = MS_W'(MS_DEFAULT);

  logic [MS_W-1:0] wr_val;

  always_comb begin
    wr_val = (cfg_ms < MIN_V) ? MIN_V : cfg_ms;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latency <= DEF_V;
    end else if (cfg_wr) begin
      latency <= wr_val;
    end
  end

  AST_LATENCY_LEGAL: assert property (@(posedge clk) disable iff (rst)
    latency >= MIN_V); // R3
  AST_LATENCY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(latency)); // R2
endmodule

// File: rtl/rft_ms_counter.sv
module rft_ms_counter #(
  parameter int MS_W = rft_pkg::RFT_MS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ms_tick,
  input  logic            byte_wr,
  input  logic            buf_nempty,
  input  logic            armed,
  input  logic            fire,
  input  logic [MS_W-1:0] latency,
  output logic            expire
);
  localparam logic [MS_W-1:0] CNT_MAX = '1;

  logic [MS_W-1:0] cnt;
  logic [MS_W:0]   cnt_nx;
  logic            run;
  logic            clr;

  always_comb begin
    run    = armed && buf_nempty && !byte_wr;
    clr    = byte_wr || fire || !armed || !buf_nempty;
    cnt_nx = {1'b0, cnt} + 1'b1;
    expire = run && ms_tick && (cnt_nx >= {1'b0, latency});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (ms_tick && cnt != CNT_MAX) begin
      cnt <= cnt_nx[MS_W-1:0];
    end
  end

  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !buf_nempty |=> cnt == '0); // R5
  AST_BYTE_RESTART: assert property (@(posedge clk) disable iff (rst)
    byte_wr |=> cnt == '0); // R6
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    !ms_tick |=> (cnt == '0 || $stable(cnt))); // R9
  AST_NO_EARLY_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    expire |-> ms_tick && buf_nempty); // R4
endmodule

// File: rtl/rft_flush_ctrl.sv
module rft_flush_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic byte_wr,
  input  logic buf_nempty,
  input  logic buf_full,
  input  logic expire,
  output logic armed,
  output logic fire,
  output logic flush_req
);
  always_comb begin
    fire = armed && (buf_full || expire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      flush_req <= fire;
      if (fire) begin
        armed <= 1'b0;
      end else if (byte_wr) begin
        armed <= 1'b1;
      end else if (!buf_nempty) begin
        armed <= 1'b0;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !flush_req); // R8
  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (armed && buf_full) |=> flush_req); // R7
  AST_DISARM_AFTER: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !armed || $past(byte_wr)); // R8
endmodule

// File: rtl/rx_flush_timer.sv
module rx_flush_timer #(
  parameter int MS_W       = rft_pkg::RFT_MS_W,
  parameter int MS_DEFAULT = rft_pkg::RFT_MS_DEFAULT,
  parameter int MS_MIN     = rft_pkg::RFT_MS_MIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ms_tick,
  input  logic            byte_wr,
  input  logic            buf_nempty,
  input  logic            buf_full,
  input  logic            cfg_wr,
  input  logic [MS_W-1:0] cfg_ms,
  output logic            flush_req
);
  logic [MS_W-1:0] latency;
  logic            expire;
  logic            armed;
  logic            fire;

  rft_latency_reg #(
    .MS_W(MS_W), .MS_DEFAULT(MS_DEFAULT), .MS_MIN(MS_MIN)
  ) u_lat (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ms(cfg_ms), .latency(latency)
  );

  rft_ms_counter #(.MS_W(MS_W)) u_cnt (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .byte_wr(byte_wr),
    .buf_nempty(buf_nempty), .armed(armed), .fire(fire),
    .latency(latency), .expire(expire)
  );

  rft_flush_ctrl u_ctl (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .buf_nempty(buf_nempty),
    .buf_full(buf_full), .expire(expire), .armed(armed), .fire(fire),
    .flush_req(flush_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !flush_req); // R1
endmodule

// File: tb/sim_rx_flush_timer.sv
`timescale 1ns/1ps
module sim_rx_flush_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ms_tick = 1'b0, byte_wr = 1'b0, buf_nempty = 1'b0, buf_full = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_ms = 8'd0;
  logic       flush_req;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rx_flush_timer u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .byte_wr(byte_wr),
    .buf_nempty(buf_nempty), .buf_full(buf_full), .cfg_wr(cfg_wr),
    .cfg_ms(cfg_ms), .flush_req(flush_req)
  );

  localparam int NV = 8;
  localparam logic [7:0] WR_V  [NV] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd40, 8'd17, 8'd255};
  localparam int         EXP_V [NV] = '{2, 2, 2, 3, 5, 40, 17, 255};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic f, output logic fl);
    @(negedge clk);
    ms_tick = t; byte_wr = w; buf_full = f;
    @(posedge clk);
    #1 fl = flush_req;
  endtask

  task automatic set_latency(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ms = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // n ticks separated by idle cycles; first = tick index that produced the flush
  task automatic ticks(input int n, output int first, output int pulses);
    logic fl;
    first = 0; pulses = 0;
    for (int i = 1; i <= n; i++) begin
      cyc(1'b1, 1'b0, 1'b0, fl);
      if (fl) begin pulses++; if (first == 0) first = i; end
      cyc(1'b0, 1'b0, 1'b0, fl);
      if (fl) pulses++;
    end
  endtask

  task automatic write_byte(output logic fl);
    cyc(1'b0, 1'b1, 1'b0, fl);
    buf_nempty = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic fl;
    int first, pulses;
    repeat (4) @(posedge clk);
    #1 chk(flush_req == 1'b0, "R1 reset output", flush_req, 0);
    @(negedge clk) rst = 1'b0;

    // R1 default latency, R9 idle cycles do not count
    write_byte(fl);
    repeat (40) cyc(1'b0, 1'b0, 1'b0, fl);
    chk(fl == 1'b0, "R9 idle no flush", fl, 0);
    ticks(20, first, pulses);
    chk(first == 16, "R1 default 16 ms", first, 16);
    chk(pulses == 1, "R8 single pulse", pulses, 1);

    // R8 no re-flush while data remains and no new byte
    ticks(300, first, pulses);
    chk(pulses == 0, "R8 no repeat flush", pulses, 0);

    // R2 R3 R4 table walk
    for (int k = 0; k < NV; k++) begin
      set_latency(WR_V[k]);
      write_byte(fl);
      ticks(EXP_V[k] + 3, first, pulses);
      chk(first == EXP_V[k], "R2/R3/R4 latency ticks", first, EXP_V[k]);
      chk(pulses == 1, "R8 one cycle high", pulses, 1);
    end

    // R6 byte write restarts; tick with byte_wr not counted
    set_latency(8'd10);
    write_byte(fl);
    ticks(7, first, pulses);
    chk(pulses == 0, "R6 before restart", pulses, 0);
    cyc(1'b1, 1'b1, 1'b0, fl);
    ticks(12, first, pulses);
    chk(first == 10, "R6 restart count", first, 10);

    // R5 empty buffer: ticks ignored, timer disarmed
    write_byte(fl);
    ticks(4, first, pulses);
    buf_nempty = 1'b0;
    ticks(30, first, pulses);
    chk(pulses == 0, "R5 empty no flush", pulses, 0);
    buf_nempty = 1'b1;
    ticks(30, first, pulses);
    chk(pulses == 0, "R5 disarmed after empty", pulses, 0);
    write_byte(fl);
    ticks(12, first, pulses);
    chk(first == 10, "R5 fresh count after empty", first, 10);

    // R7 full flushes at once and clears the count
    write_byte(fl);
    ticks(6, first, pulses);
    cyc(1'b0, 1'b0, 1'b1, fl);
    chk(fl == 1'b1, "R7 full flush", fl, 1);
    pulses = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 1'b0, 1'b1, fl);
      if (fl) pulses++;
    end
    chk(pulses == 0, "R8 full held no repeat", pulses, 0);
    cyc(1'b0, 1'b0, 1'b0, fl);
    write_byte(fl);
    ticks(12, first, pulses);
    chk(first == 10, "R7 count cleared by full", first, 10);

    // R1 reset restores default
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1 chk(flush_req == 1'b0, "R1 output after reset", flush_req, 0);
    write_byte(fl);
    ticks(20, first, pulses);
    chk(first == 16, "R1 default restored", first, 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule